// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block decides which of the output queues that belong to one port may send next. Each queue comes with an 8-bit round mask. A 3-bit round counter selects one bit of every mask, and only queues whose selected bit is set take part in that round. The patterns are chosen so that the set bits of a mask are spread over the eight rounds. As a result, a queue's share of the service follows the number of set bits in its mask, and its turns are not bunched together. A package function turns a weight from 0 to 8 into such a mask, and weight 9 marks a queue as strict priority.

A group of strict-priority queues can sit at the low queue indices. A queue in that group that holds data always wins, and the lowest index in the group wins first. The remaining queues are scanned upward from a rotating pointer. The last queue of the port closes each round. The block issues a registered one-hot grant together with a valid bit. The grant is held until downstream accepts it. The next decision is taken in the cycle after the accept.

Top module: `wrr_sched`

## Requirements
- R1: While `rst` is high, at the following clock edge `grant_vld` is 0 and `grant` is all zeros.
- R2: While `grant_vld` is 1, `grant` has exactly one bit set. While `grant_vld` is 0, `grant` is zero. Bit q of `grant` selects queue q.
- R3: A valid grant keeps the same value, even if the queue's data goes away, until `accept` is sampled high. In the cycle after the accept, `grant_vld` is 0, and the next grant appears one cycle later at the earliest.
- R4: The strict group is the set of queues with `q_strict` set, at or below the first queue marked in `q_strict_last`, and inside the port. A `q_strict` flag above that marker is ignored, and that queue is treated as weighted. If any queue in the strict group holds data, the lowest-indexed such queue is granted ahead of every weighted queue.
- R5: A weighted queue q is eligible in round r when it holds data and bit r of its mask, `q_round_mask[q*8 + r]`, is 1. The round starts at 0 and the pointer starts at queue 0 after reset. The lowest eligible queue at or above the pointer is granted. When a weighted grant is accepted, the pointer moves to the next queue. Accepting a grant of the last queue of the port sets the pointer to 0 and advances the round by one, modulo 8.
- R6: With masks 0xFF and 0x01 on two always-busy queues, the first queue receives 8 grants for each single grant of the second over a full cycle of rounds.
- R7: When weighted queues hold data but none is eligible at or above the pointer, the round advances by one per cycle (pointer to 0) without a grant. A queue whose only mask bit is round 7 is first granted in the 8th decision cycle after reset. When no queue holds data, no grant is issued.
- R8: The port ends at the first queue marked in `q_port_last`. Queues above it are never granted.
- R9: A change of a mask takes effect at the next decision, which is the one made after the current grant is accepted.
- R10: The function `weight_to_mask` maps weights 0 to 8 to 0x00, 0x01, 0x11, 0x49, 0x55, 0x57, 0x77, 0x7F and 0xFF. Weight 9 (strict) and any larger value map to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_has_data | input | NQ | Queue q holds at least one command |
| q_round_mask | input | NQ*RW | Round mask of queue q in bits [q*RW +: RW] |
| q_strict | input | NQ | Queue q is strict priority |
| q_strict_last | input | NQ | Marks the last queue of the strict group |
| q_port_last | input | NQ | Marks the last queue of the port |
| accept | input | 1 | Downstream takes the current grant |
| grant | output | NQ | One-hot grant |
| grant_vld | output | 1 | Grant is valid |

## Verification
The assertions assume that `accept` is only raised while `grant_vld` is high. They also assume that a `q_has_data` bit seen in a decision cycle reflects real data, so that a fresh grant must point at a queue that held data one cycle earlier. The bench keeps within these assumptions in two ways. It drives `accept` from the scoreboard monitor only when it sees a valid grant, and it drops it again on the next falling edge. Configuration and data are changed only after a reset, or, in the directed mask-change case, while a grant is held and not yet accepted.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int STRICT_WEIGHT = 9;

  // Spread-bit round mask for a 0..8 weight; strict and out-of-range give all ones
  function automatic logic [7:0] weight_to_mask(input logic [3:0] w);
    case (w)
      4'd0:    return 8'h00;
      4'd1:    return 8'h01;
      4'd2:    return 8'h11;
      4'd3:    return 8'h49;
      4'd4:    return 8'h55;
      4'd5:    return 8'h57;
      4'd6:    return 8'h77;
      4'd7:    return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/wrr_span.sv
// upto[i] is 1 when no mark is set at an index below i
module wrr_span #(
  parameter int N = 8
) (
  input  logic [N-1:0] marks,
  output logic [N-1:0] upto
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < N; k++) begin
      upto[k] = !seen;
      seen    = seen | marks[k];
    end
  end
endmodule

// File: rtl/wrr_lowest.sv
// Lowest set bit finder
module wrr_lowest #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched #(
  parameter int NQ = 8,
  parameter int RW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NQ-1:0]    q_has_data,
  input  logic [NQ*RW-1:0] q_round_mask,
  input  logic [NQ-1:0]    q_strict,
  input  logic [NQ-1:0]    q_strict_last,
  input  logic [NQ-1:0]    q_port_last,
  input  logic             accept,
  output logic [NQ-1:0]    grant,
  output logic             grant_vld
);
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int RBW = (RW > 1) ? $clog2(RW) : 1;

  logic [QW-1:0]  ptr_q, gidx_q, last_idx, s_idx, w_idx;
  logic [RBW-1:0] rnd_q, rnd_inc;
  logic           g_strict_q, s_found, w_found;
  logic [NQ-1:0]  in_port, in_sregion, strict_grp, rbit, at_or_above;
  logic [NQ-1:0]  s_elig, w_data, w_elig;

  wrr_span #(.N(NQ)) u_port_span (.marks(q_port_last),   .upto(in_port));
  wrr_span #(.N(NQ)) u_sgrp_span (.marks(q_strict_last), .upto(in_sregion));

  genvar gi;
  generate
    for (gi = 0; gi < NQ; gi++) begin : g_queue
      logic [RW-1:0] qmask;
      assign qmask           = q_round_mask[gi*RW +: RW];
      assign rbit[gi]        = qmask[rnd_q];
      assign at_or_above[gi] = (gi >= int'(ptr_q));
    end
  endgenerate

  assign strict_grp = q_strict & in_sregion & in_port;
  assign s_elig     = strict_grp & q_has_data;
  assign w_data     = in_port & ~strict_grp & q_has_data;
  assign w_elig     = w_data & rbit & at_or_above;

  wrr_lowest #(.N(NQ)) u_strict_pick (.vec(s_elig), .found(s_found), .idx(s_idx));
  wrr_lowest #(.N(NQ)) u_wrr_pick    (.vec(w_elig), .found(w_found), .idx(w_idx));

  always_comb begin
    last_idx = '0;
    for (int k = 0; k < NQ; k++)
      if (in_port[k]) last_idx = QW'(k);
  end

  assign rnd_inc = (rnd_q == RBW'(RW - 1)) ? '0 : rnd_q + RBW'(1);

  // Strict grants leave pointer and round untouched
  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= '0;
      grant_vld  <= 1'b0;
      ptr_q      <= '0;
      rnd_q      <= '0;
      gidx_q     <= '0;
      g_strict_q <= 1'b0;
    end else if (grant_vld) begin
      if (accept) begin
        grant     <= '0;
        grant_vld <= 1'b0;
        if (!g_strict_q) begin
          if (gidx_q == last_idx) begin
            ptr_q <= '0;
            rnd_q <= rnd_inc;
          end else begin
            ptr_q <= gidx_q + QW'(1);
          end
        end
      end
    end else if (s_found) begin
      grant      <= NQ'(1) << s_idx;
      grant_vld  <= 1'b1;
      gidx_q     <= s_idx;
      g_strict_q <= 1'b1;
    end else if (w_found) begin
      grant      <= NQ'(1) << w_idx;
      grant_vld  <= 1'b1;
      gidx_q     <= w_idx;
      g_strict_q <= 1'b0;
    end else if (|w_data) begin
      ptr_q <= '0;
      rnd_q <= rnd_inc;
    end
  end
endmodule

// File: rtl/wrr_sched_chk.sv
module wrr_sched_chk #(
  parameter int NQ = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [NQ-1:0] q_has_data,
  input logic [NQ-1:0] q_strict,
  input logic [NQ-1:0] q_port_last,
  input logic          accept,
  input logic [NQ-1:0] grant,
  input logic          grant_vld
);
  logic [NQ-1:0] beyond;
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < NQ; k++) begin
      beyond[k] = seen;
      seen      = seen | q_port_last[k];
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> !grant_vld && grant == '0);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> $countones(grant) == 1);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |-> grant == '0);
  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld && !accept |=> grant_vld && $stable(grant));
  // R3
  accept_gap_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld && accept |=> !grant_vld);
  // R7
  grant_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) |-> (grant & $past(q_has_data)) != '0);
  // R8
  port_bound_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) |-> (grant & $past(beyond)) == '0);
  // R4
  strict_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) && $past(q_strict[0] && q_has_data[0]) |-> grant[0]);
endmodule

bind wrr_sched wrr_sched_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst(rst), .q_has_data(q_has_data), .q_strict(q_strict),
  .q_port_last(q_port_last), .accept(accept), .grant(grant), .grant_vld(grant_vld)
);

// File: tb/sim_wrr_sched.sv
module sim_wrr_sched;
  import wrr_pkg::*;
  localparam int CLK_PER = 10;
  localparam int NQ = 8;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NQ-1:0] q_has_data = '0, q_strict = '0, q_strict_last = '0, q_port_last = '0;
  logic [NQ*RW-1:0] q_round_mask;
  logic accept = 1'b0;
  logic [NQ-1:0] grant;
  logic grant_vld;
  logic [RW-1:0] c_mask [NQ];

  int checks = 0, errors = 0;
  int m_ptr = 0, m_rnd = 0;
  int exp_q[$];
  bit auto_acc = 1'b0;
  string cur_req = "R5";

  always #(CLK_PER/2) clk = ~clk;

  always_comb
    for (int i = 0; i < NQ; i++) q_round_mask[i*RW +: RW] = c_mask[i];

  wrr_sched #(.NQ(NQ), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .q_has_data(q_has_data), .q_round_mask(q_round_mask),
    .q_strict(q_strict), .q_strict_last(q_strict_last), .q_port_last(q_port_last),
    .accept(accept), .grant(grant), .grant_vld(grant_vld)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Reference: next granted queue from the requirements, -1 if none
  task automatic model_next(output int q);
    bit inp[NQ];
    bit sg[NQ];
    bit seen, sseen, anyw;
    int last;
    q = -1; seen = 0; sseen = 0; anyw = 0; last = 0;
    for (int i = 0; i < NQ; i++) begin
      inp[i] = !seen;
      if (inp[i]) last = i;
      seen = seen | q_port_last[i];
      sg[i] = q_strict[i] && !sseen && inp[i];
      sseen = sseen | q_strict_last[i];
    end
    for (int i = 0; i < NQ; i++)
      if (sg[i] && q_has_data[i]) begin q = i; return; end
    for (int i = 0; i < NQ; i++)
      if (inp[i] && !sg[i] && q_has_data[i]) anyw = 1;
    if (!anyw) return;
    for (int k = 0; k <= RW; k++) begin
      for (int i = m_ptr; i <= last; i++)
        if (!sg[i] && q_has_data[i] && c_mask[i][m_rnd]) begin
          q = i;
          if (i == last) begin m_ptr = 0; m_rnd = (m_rnd + 1) % RW; end
          else m_ptr = i + 1;
          return;
        end
      m_ptr = 0;
      m_rnd = (m_rnd + 1) % RW;
    end
  endtask

  task automatic do_reset();
    auto_acc = 0;
    accept = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_ptr = 0;
    m_rnd = 0;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NQ; i++) c_mask[i] = 8'h00;
    q_has_data = '0; q_strict = '0; q_strict_last = '0; q_port_last = '0;
  endtask

  // Driver: push expected grant order, let the monitor accept and compare
  task automatic run_seq(int n, string req);
    int e;
    int guard;
    cur_req = req;
    for (int k = 0; k < n; k++) begin
      model_next(e);
      if (e >= 0) exp_q.push_back(e);
    end
    auto_acc = 1;
    guard = 0;
    while (exp_q.size() > 0 && guard < 4000) begin
      @(posedge clk);
      guard++;
    end
    check(exp_q.size() == 0, req, "sequence drained", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    auto_acc = 0;
    accept = 0;
  endtask

  // Monitor
  always @(negedge clk) begin
    int e;
    if (auto_acc) begin
      if (grant_vld && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(grant == NQ'(1 << e), cur_req, "grant order", int'(grant), 1 << e);
        accept = 1;
      end else begin
        accept = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL all watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] tbl [10];
    bit ok;
    clear_cfg();
    do_reset();

    // R1: reset state
    check(grant_vld == 0 && grant == '0, "R1", "reset state", int'(grant), 0);

    // R10: weight-to-mask mapping
    tbl = '{8'h00, 8'h01, 8'h11, 8'h49, 8'h55, 8'h57, 8'h77, 8'h7F, 8'hFF, 8'hFF};
    for (int w = 0; w < 10; w++)
      check(weight_to_mask(4'(w)) == tbl[w], "R10", "weight mask", int'(weight_to_mask(4'(w))), int'(tbl[w]));
    check(weight_to_mask(4'd12) == 8'hFF, "R10", "weight above strict", int'(weight_to_mask(4'd12)), 8'hFF);

    // R6 / R2: 0x01 versus 0xFF, two full cycles of rounds
    clear_cfg();
    c_mask[0] = 8'h01; c_mask[1] = 8'hFF;
    q_port_last = 8'b0000_0010; q_has_data = 8'b0000_0011;
    do_reset();
    run_seq(18, "R6");

    // R5: spread masks, one empty queue skipped
    clear_cfg();
    c_mask[0] = 8'h11; c_mask[1] = 8'h49; c_mask[2] = 8'h55; c_mask[3] = 8'h77;
    q_port_last = 8'b0000_1000; q_has_data = 8'b0000_1011;
    do_reset();
    run_seq(20, "R5");

    // R8: queues past the port end carry data but are never granted
    clear_cfg();
    c_mask[0] = 8'h01; c_mask[1] = 8'h55;
    for (int i = 2; i < NQ; i++) c_mask[i] = 8'hFF;
    q_port_last = 8'b0000_0100; q_has_data = 8'hFF;
    do_reset();
    run_seq(16, "R8");

    // R4: strict queue with data beats weighted queues
    clear_cfg();
    for (int i = 0; i < 4; i++) c_mask[i] = 8'hFF;
    q_strict = 8'b0000_0011; q_strict_last = 8'b0000_0010; q_port_last = 8'b0000_1000;
    q_has_data = 8'b0000_1110;
    do_reset();
    run_seq(6, "R4");
    // R4: lowest strict index wins
    q_has_data = 8'b0000_1111;
    do_reset();
    run_seq(4, "R4");
    // R4: strict flag above the strict-last marker is ignored
    q_strict = 8'b0000_0111; q_has_data = 8'b0000_1100;
    do_reset();
    run_seq(6, "R4");

    // R7: only round 7 enabled, first grant in the 8th decision cycle
    clear_cfg();
    c_mask[1] = 8'h80;
    q_port_last = 8'b0000_0010; q_has_data = 8'b0000_0011;
    do_reset();
    repeat (7) @(posedge clk);
    @(negedge clk);
    check(grant_vld == 0, "R7", "no grant before round 7", int'(grant_vld), 0);
    @(posedge clk);
    @(negedge clk);
    check(grant_vld == 1 && grant == 8'h02, "R7", "grant in round 7", int'(grant), 2);

    // R7: no data, no grant
    clear_cfg();
    for (int i = 0; i < NQ; i++) c_mask[i] = 8'hFF;
    do_reset();
    ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (grant_vld) ok = 0;
    end
    check(ok, "R7", "idle without data", int'(grant_vld), 0);

    // R3 and R9: held grant, accept gap, mask change at next decision
    clear_cfg();
    c_mask[0] = 8'h00; c_mask[1] = 8'hFF;
    q_port_last = 8'b0000_0010; q_has_data = 8'b0000_0011;
    do_reset();
    @(posedge clk);
    @(negedge clk);
    check(grant_vld == 1 && grant == 8'h02, "R3", "first grant", int'(grant), 2);
    q_has_data = '0;
    ok = 1;
    repeat (4) begin
      @(negedge clk);
      if (!grant_vld || grant != 8'h02) ok = 0;
    end
    check(ok, "R3", "grant held without accept", int'(grant), 2);
    q_has_data = 8'b0000_0011;
    c_mask[0] = 8'hFF;
    accept = 1;
    @(posedge clk);
    @(negedge clk);
    accept = 0;
    check(grant_vld == 0, "R3", "gap after accept", int'(grant_vld), 0);
    @(posedge clk);
    @(negedge clk);
    check(grant_vld == 1 && grant == 8'h01, "R9", "new mask used", int'(grant), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule